// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the address for a four-beat burst. A start address is captured when either of two active-low strobes is low at a rising clock edge: a processor-side strobe or a controller-side strobe. After that, each rising edge with the active-low advance input low moves the two least significant address bits to the next beat. The upper address bits keep the value captured at the load for the whole burst.

A static order-select input chooses the beat order. In linear order the two low bits count up modulo four from the start value. In interleaved order they are the start value XOR a two-bit beat count. After four advances the low bits are back at the start value. Bursting is optional: a new start address can be loaded on every cycle with no lost cycle. All inputs are sampled on the rising clock edge, and reset is synchronous and active high.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_out` becomes all zeros after that edge, and the beat count restarts.
- R2: When `proc_stb_n` is low at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge, starting in the following cycle.
- R3: When `ctrl_stb_n` is low at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge, starting in the following cycle. If both strobes are low, the address is loaded once.
- R4: With `order_sel` = 0 (linear), each edge where `adv_n` is low and both strobes are high sets `addr_out[1:0]` to the previous low bits plus one, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_sel` = 1 (interleaved), the low bits after the k-th advance are the start low bits XOR k (mod 4). For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R6: After four advances in either order, `addr_out[1:0]` is back at the loaded start value.
- R7: When both strobes and `adv_n` are high at an edge, `addr_out` does not change, whatever `addr_in` is.
- R8: When a strobe and `adv_n` are both low at the same edge, the load wins: `addr_out` becomes `addr_in` and the beat count restarts at zero.
- R9: `addr_out[ADDR_W-1:2]` changes only at a load or a reset. Advancing, and any `addr_in` value without a strobe, leave it unchanged.
- R10: Loads in consecutive cycles each take effect on the next cycle, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| proc_stb_n | input | 1 | Processor-side load strobe, active low |
| ctrl_stb_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Start address, sampled when a strobe is low |
| addr_out | output | ADDR_W | Registered burst address |

## Verification
Two functions can fall in the same cycle: a load strobe and an advance request. The stimulus table drives a strobe and a low `adv_n` at the same edge, once at the start of a burst. It then checks that the output is the newly sampled address and not a stepped value, and that the next advance gives beat one of the new burst. Back-to-back loads on alternating strobes, and on both strobes together, check that a load needs no extra cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int LOW_W    = 2;
    localparam int BEATS    = 1 << LOW_W;

    typedef logic [LOW_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } cmd_e;

    typedef struct packed {
        beat_t start;
        beat_t beat;
    } beat_state_t;

    function automatic beat_t map_beat(beat_t start, beat_t beat, order_e ord);
        beat_t res;
        if (ord == ORD_INTERLEAVE) res = start ^ beat;
        else                       res = start + beat;
        return res;
    endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic proc_stb_n,
    input  logic ctrl_stb_n,
    input  logic adv_n,
    output cmd_e cmd
);
    always_comb begin
        if (!proc_stb_n || !ctrl_stb_n) cmd = CMD_LOAD;
        else if (!adv_n)                cmd = CMD_STEP;
        else                            cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
    import burst_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  cmd_e        cmd,
    input  beat_t       start_in,
    output beat_state_t state_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    state_q.start <= start_in;
                    state_q.beat  <= '0;
                end
                CMD_STEP: state_q.beat <= state_q.beat + beat_t'(1);
                default:  state_q <= state_q;
            endcase
        end
    end

    // R8: a load restarts the beat count
    a_r8_load_restarts: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (state_q.beat == '0));
    // R6: each step moves the count by one, so four steps wrap
    a_r6_beat_step: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_STEP) |=> (state_q.beat == beat_t'($past(state_q.beat) + 1'b1)));
    a_r7_start_kept: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(state_q.start));
endmodule

// File: rtl/burst_upper_reg.sv
module burst_upper_reg
    import burst_seq_pkg::*;
#(
    parameter int UP_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  cmd_e            cmd,
    input  logic [UP_W-1:0] upper_in,
    output logic [UP_W-1:0] upper_q
);
    always_ff @(posedge clk) begin
        if (rst)                  upper_q <= '0;
        else if (cmd == CMD_LOAD) upper_q <= upper_in;
    end

    // R9: upper bits only move on a load
    a_r9_upper_stable: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_LOAD) |=> $stable(upper_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  beat_state_t state,
    input  logic        order_sel,
    output beat_t       low_out
);
    order_e ord;
    assign ord     = order_e'(order_sel);
    assign low_out = map_beat(state.start, state.beat, ord);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_stb_n,
    input  logic              ctrl_stb_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int UP_W = ADDR_W - LOW_W;

    cmd_e            cmd;
    beat_state_t     bstate;
    logic [UP_W-1:0] upper_q;
    beat_t           low_bits;

    burst_cmd_decode u_dec (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .cmd        (cmd)
    );

    burst_beat_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .start_in (addr_in[LOW_W-1:0]),
        .state_q  (bstate)
    );

    burst_upper_reg #(.UP_W(UP_W)) u_up (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .upper_in (addr_in[ADDR_W-1:LOW_W]),
        .upper_q  (upper_q)
    );

    burst_order_map u_map (
        .state     (bstate),
        .order_sel (order_sel),
        .low_out   (low_bits)
    );

    assign addr_out = {upper_q, low_bits};

    // R2
    a_r2_proc_load: assert property (@(posedge clk) disable iff (rst)
        !proc_stb_n |=> (addr_out == $past(addr_in)));
    // R3
    a_r3_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        !ctrl_stb_n |=> (addr_out == $past(addr_in)));
    // R7
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (proc_stb_n && ctrl_stb_n && adv_n && $stable(order_sel)) |=> $stable(addr_out));
    // R4
    a_r4_linear_step: assert property (@(posedge clk) disable iff (rst)
        (proc_stb_n && ctrl_stb_n && !adv_n && !order_sel) |=>
        (order_sel || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          proc_stb_n = 1'b1;
    logic          ctrl_stb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .order_sel  (order_sel),
        .addr_in    (addr_in),
        .addr_out   (addr_out)
    );

    typedef struct packed {
        logic          p_n;
        logic          c_n;
        logic          a_n;
        logic          ord;
        logic [AW-1:0] a_in;
        logic [AW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b1, 1'b0, 20'h12341, 20'h12341, 4'd2},  // R2 load
        '{1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 20'h12342, 4'd4},  // R4
        '{1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 20'h12343, 4'd4},  // R4
        '{1'b1, 1'b1, 1'b1, 1'b0, 20'hFFFFF, 20'h12343, 4'd7},  // R7 hold
        '{1'b1, 1'b1, 1'b0, 1'b0, 20'hFFFFF, 20'h12340, 4'd4},  // R4 wrap 11->00, R9
        '{1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 20'h12341, 4'd6},  // R6
        '{1'b1, 1'b0, 1'b1, 1'b1, 20'h5A5A5, 20'h5A5A5, 4'd3},  // R3 load
        '{1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 20'h5A5A4, 4'd5},  // R5
        '{1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 20'h5A5A7, 4'd5},  // R5
        '{1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 20'h5A5A6, 4'd5},  // R5
        '{1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 20'h5A5A5, 4'd6},  // R6
        '{1'b0, 1'b1, 1'b0, 1'b1, 20'h0F0F2, 20'h0F0F2, 4'd8},  // R8 load+adv
        '{1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 20'h0F0F3, 4'd5},  // R5, R8 beat restarted
        '{1'b1, 1'b1, 1'b0, 1'b1, 20'hFFFFF, 20'h0F0F0, 4'd9},  // R9
        '{1'b1, 1'b1, 1'b0, 1'b1, 20'h00000, 20'h0F0F1, 4'd5},  // R5
        '{1'b1, 1'b0, 1'b1, 1'b0, 20'h33333, 20'h33333, 4'd10}, // R10
        '{1'b0, 1'b1, 1'b1, 1'b0, 20'h44440, 20'h44440, 4'd10}, // R10
        '{1'b0, 1'b0, 1'b1, 1'b0, 20'h77777, 20'h77777, 4'd3},  // R3 both strobes
        '{1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 20'h77774, 4'd4},  // R4
        '{1'b1, 1'b1, 1'b0, 1'b0, 20'h00000, 20'h77775, 4'd4}   // R4
    };

    task automatic check(input logic [AW-1:0] exp, input int req);
        n_chk++;
        if (addr_out !== exp) begin
            n_bad++;
            $display("FAIL R%0d: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic drive(input logic p, input logic c, input logic a,
                         input logic o, input logic [AW-1:0] ai);
        @(negedge clk);
        proc_stb_n = p;
        ctrl_stb_n = c;
        adv_n      = a;
        order_sel  = o;
        addr_in    = ai;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check('0, 1); // R1 reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].p_n, VEC[i].c_n, VEC[i].a_n, VEC[i].ord, VEC[i].a_in);
            check(VEC[i].exp, int'(VEC[i].req));
        end

        // R1: reset in mid-burst clears address and beat count
        drive(1'b1, 1'b1, 1'b1, 1'b0, 20'h0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check('0, 1);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 20'hABCDE);
        check(20'h00001, 4); // R4 from reset start 00, R9 upper ignored

        // R5: interleaved from start 11 gives 11,10,01,00
        drive(1'b0, 1'b1, 1'b1, 1'b1, 20'h8000B);
        check(20'h8000B, 2);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 20'h0);
        check(20'h8000A, 5);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 20'h0);
        check(20'h80009, 5);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 20'h0);
        check(20'h80008, 5);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 20'h0);
        check(20'h8000B, 6);
        // R7: strobes high, junk address, no advance
        drive(1'b1, 1'b1, 1'b1, 1'b1, 20'h12345);
        check(20'h8000B, 7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R1..all): run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule